// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block keeps one pending flag for each of thirteen asynchronous interrupt sources. When the core asks for an interrupt by raising a deliver strobe, the block picks at most one eligible source, reports it on a registered grant (one-hot and encoded), and updates the pending flags. Each source follows its own clear-on-delivery rule. The core uses the summary request line to decide whether it needs to ask at all.

Eligibility depends on processor state inputs: the external enable, the critical enable, the hypervisor-mode flag, a hypervisor decrementer enable, and a partition bit that keeps external interrupts in the guest. Reset and machine check are always eligible. The most important sources block all less important ones. A power-save entry strobe drops any waiting hypervisor decrementer request. Entering the exception and the timers that raise the requests are outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, every pending flag is clear, `irq_req_o` is 0, `grant_valid_o` is 0, `grant_onehot_o` is 0 and `grant_id_o` is 15 (the "none" code).
- R2: A `set_i` bit sets its pending flag at the next clock edge, and a `clr_i` bit clears it. A source that is both set and cleared in the same cycle is pending afterwards.
- R3: Source indices, from highest to lowest priority, are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. The grant goes to the eligible source with the lowest index. `grant_id_o` carries that index, and `grant_onehot_o` has only bit index set.
- R4: Reset (0) and machine check (1) are eligible regardless of state inputs, and their flags clear on delivery.
- R5: Hypervisor decrementer (2) is eligible only when `hdec_en_i` is 1 and either `ext_en_i` is 1 or `hv_mode_i` is 0. Its flag clears on delivery.
- R6: External (3) is eligible when `ext_en_i` is 1, or when HV_CAPABLE is 1, `hv_mode_i` is 0 and `guest_ext_i` is 0. Delivery never clears its flag.
- R7: Critical external (4) is eligible only when `crit_en_i` is 1. Delivery never clears its flag.
- R8: Sources 5 to 12 are eligible only when `ext_en_i` is 1. They clear on delivery, except the decrementer (9), which clears on delivery only when the parameter DEC_AUTO_CLEAR is 1 (the default).
- R9: If no source is eligible when `deliver_i` is high, the grant that follows has `grant_valid_o` 0, `grant_id_o` 15 and `grant_onehot_o` 0, and no pending flag changes.
- R10: While `pwr_save_i` is high, the hypervisor decrementer flag is cleared at the clock edge, unless `set_i[2]` raises it again in the same cycle.
- R11: `irq_req_o` is 1 exactly when at least one pending flag is set. It follows the pending register updated by the last edge.
- R12: The grant is registered. It reflects the pending flags and state inputs of the cycle in which `deliver_i` was high, lasts for one cycle, and is "none" with `grant_valid_o` 0 in any cycle after `deliver_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 13 | Per-source request set |
| clr_i | input | 13 | Per-source request clear |
| deliver_i | input | 1 | Arbitrate and deliver this cycle |
| ext_en_i | input | 1 | External interrupt enable state |
| crit_en_i | input | 1 | Critical interrupt enable state |
| hv_mode_i | input | 1 | Processor in hypervisor mode |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| guest_ext_i | input | 1 | Partition bit: externals stay in guest |
| pwr_save_i | input | 1 | Power-save entry, discards hypervisor decrementer |
| grant_valid_o | output | 1 | A source was delivered |
| grant_onehot_o | output | 13 | One-hot delivered source |
| grant_id_o | output | 4 | Encoded delivered source, 15 = none |
| irq_req_o | output | 1 | Some request is pending |

## Verification
The assertions expect the state inputs to be stable around each deliver strobe and the reset to be held for at least one edge. They also expect `set_i`, `clr_i` and `pwr_save_i` to be ordinary levels sampled at the edge. The bench drives all of these inputs only on falling edges. It sweeps all 32 combinations of the five state bits against empty, single-source, full and mixed pending patterns, so each gating rule is exercised with both of its values. Directed sequences then cover repeated delivery, the set-versus-clear collision and power-save discard.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC    = 13;
  localparam int IDW     = 4;
  localparam logic [IDW-1:0] NONE_ID = '1;

  localparam int S_RST   = 0;
  localparam int S_MCK   = 1;
  localparam int S_HDEC  = 2;
  localparam int S_EXT   = 3;
  localparam int S_CEXT  = 4;
  localparam int S_WDT   = 5;
  localparam int S_CDB   = 6;
  localparam int S_FIT   = 7;
  localparam int S_PIT   = 8;
  localparam int S_DEC   = 9;
  localparam int S_DB    = 10;
  localparam int S_PERF  = 11;
  localparam int S_THERM = 12;

  // Sources whose flag drops when they are granted.
  function automatic logic [NSRC-1:0] clear_rule(input bit dec_clr);
    logic [NSRC-1:0] m;
    m = '1;
    m[S_EXT]  = 1'b0;
    m[S_CEXT] = 1'b0;
    m[S_DEC]  = dec_clr;
    return m;
  endfunction
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] dlv_clr_i,
  input  logic [N-1:0] discard_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~(clr_i | dlv_clr_i | discard_i)) | set_i;
  end

  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R2
  AST_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (discard_i != '0) |=> ((pend_q & $past(discard_i) & ~$past(set_i)) == '0)); // R10
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
#(
  parameter bit HV_CAPABLE = 1'b1
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic            ext_en_i,
  input  logic            crit_en_i,
  input  logic            hv_mode_i,
  input  logic            hdec_en_i,
  input  logic            guest_ext_i,
  output logic [NSRC-1:0] elig_o
);
  logic [NSRC-1:0] allow;

  always_comb begin
    allow          = {NSRC{ext_en_i}};
    allow[S_RST]   = 1'b1;
    allow[S_MCK]   = 1'b1;
    allow[S_HDEC]  = hdec_en_i & (ext_en_i | ~hv_mode_i);
    allow[S_EXT]   = ext_en_i | (HV_CAPABLE & ~hv_mode_i & ~guest_ext_i);
    allow[S_CEXT]  = crit_en_i;
  end

  assign elig_o = pend_i & allow;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N   = 13,
  parameter int IDW = 4,
  parameter logic [IDW-1:0] NONE = '1
) (
  input  logic [N-1:0]   req_i,
  output logic [N-1:0]   pick_o,
  output logic [IDW-1:0] id_o,
  output logic           any_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick_o[i]    = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end

  assign any_o = blocked[N];

  always_comb begin
    id_o = NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter bit HV_CAPABLE     = 1'b1,
  parameter bit DEC_AUTO_CLEAR = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            deliver_i,
  input  logic            ext_en_i,
  input  logic            crit_en_i,
  input  logic            hv_mode_i,
  input  logic            hdec_en_i,
  input  logic            guest_ext_i,
  input  logic            pwr_save_i,
  output logic            grant_valid_o,
  output logic [NSRC-1:0] grant_onehot_o,
  output logic [IDW-1:0]  grant_id_o,
  output logic            irq_req_o
);
  localparam logic [NSRC-1:0] CLR_MASK = clear_rule(DEC_AUTO_CLEAR);

  logic [NSRC-1:0] pend, elig, pick, dlv_clr, discard;
  logic [IDW-1:0]  pick_id;
  logic            pick_any;

  irq_gate #(.HV_CAPABLE(HV_CAPABLE)) u_gate (
    .pend_i(pend), .ext_en_i(ext_en_i), .crit_en_i(crit_en_i),
    .hv_mode_i(hv_mode_i), .hdec_en_i(hdec_en_i),
    .guest_ext_i(guest_ext_i), .elig_o(elig)
  );

  irq_prio #(.N(NSRC), .IDW(IDW), .NONE(NONE_ID)) u_prio (
    .req_i(elig), .pick_o(pick), .id_o(pick_id), .any_o(pick_any)
  );

  assign dlv_clr = deliver_i ? (pick & CLR_MASK) : '0;

  always_comb begin
    discard         = '0;
    discard[S_HDEC] = pwr_save_i;
  end

  irq_pending_reg #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_i),
    .dlv_clr_i(dlv_clr), .discard_i(discard), .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (rst || !deliver_i) begin
      grant_valid_o  <= 1'b0;
      grant_onehot_o <= '0;
      grant_id_o     <= NONE_ID;
    end else begin
      grant_valid_o  <= pick_any;
      grant_onehot_o <= pick;
      grant_id_o     <= pick_id;
    end
  end

  assign irq_req_o = |pend;

  AST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_onehot_o)); // R3
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
    grant_valid_o |-> (grant_id_o != NONE_ID && grant_onehot_o[grant_id_o])); // R3
  AST_RST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (deliver_i && pend[S_RST]) |=> (grant_valid_o && grant_id_o == IDW'(S_RST))); // R4
  AST_EXT_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend[S_EXT] && !clr_i[S_EXT]) |=> pend[S_EXT]); // R6
  AST_CEXT_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend[S_CEXT] && !clr_i[S_CEXT]) |=> pend[S_CEXT]); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (deliver_i && !pick_any && set_i == '0 && clr_i == '0 && !pwr_save_i)
      |=> ($stable(pend) && !grant_valid_o)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    grant_valid_o |-> $past(deliver_i)); // R12
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] set_i = '0, clr_i = '0;
  logic deliver_i = 1'b0, ext_en_i = 1'b0, crit_en_i = 1'b0, hv_mode_i = 1'b0;
  logic hdec_en_i = 1'b0, guest_ext_i = 1'b0, pwr_save_i = 1'b0;
  logic grant_valid_o, irq_req_o;
  logic [N-1:0] grant_onehot_o;
  logic [3:0] grant_id_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [N-1:0] model;

  always #10 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_i), .deliver_i(deliver_i),
    .ext_en_i(ext_en_i), .crit_en_i(crit_en_i), .hv_mode_i(hv_mode_i),
    .hdec_en_i(hdec_en_i), .guest_ext_i(guest_ext_i), .pwr_save_i(pwr_save_i),
    .grant_valid_o(grant_valid_o), .grant_onehot_o(grant_onehot_o),
    .grant_id_o(grant_id_o), .irq_req_o(irq_req_o)
  );

  function automatic bit ok(int k, logic [4:0] s);
    // s = {ee, ce, hv, hdice, guest}
    case (k)
      0, 1: return 1'b1;
      2:    return s[1] && (s[4] || !s[2]);
      3:    return s[4] || (!s[2] && !s[0]);
      4:    return s[3];
      default: return s[4];
    endcase
  endfunction

  function automatic int winner(logic [N-1:0] p, logic [4:0] s);
    for (int k = 0; k < N; k++) if (p[k] && ok(k, s)) return k;
    return 15;
  endfunction

  function automatic bit drops(int k);
    return !(k == 3 || k == 4);
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic put_state(logic [4:0] s);
    {ext_en_i, crit_en_i, hv_mode_i, hdec_en_i, guest_ext_i} = s;
  endtask

  task automatic load(logic [N-1:0] pat);
    @(negedge clk); clr_i = '1; set_i = '0; tick();
    @(negedge clk); clr_i = '0; set_i = pat; tick();
    @(negedge clk); set_i = '0;
    model = pat;
  endtask

  task automatic deliver(logic [4:0] s, string req);
    int w;
    @(negedge clk); put_state(s); deliver_i = 1'b1;
    w = winner(model, s);
    tick();
    check(grant_id_o == 4'(w), req, grant_id_o, w);
    check(grant_valid_o == (w != 15), req, grant_valid_o, w != 15);
    check(grant_onehot_o == ((w == 15) ? '0 : (N'(1) << w)), req, grant_onehot_o,
          (w == 15) ? 0 : (1 << w));
    if (w != 15 && drops(w)) model[w] = 1'b0;
    check(irq_req_o == (model != '0), "R11", irq_req_o, model != '0);
    @(negedge clk); deliver_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check(irq_req_o == 1'b0, "R1", irq_req_o, 0);
    check(grant_valid_o == 1'b0 && grant_onehot_o == '0, "R1", grant_valid_o, 0);
    check(grant_id_o == 4'd15, "R1", grant_id_o, 15);

    // R3 R4 R5 R6 R7 R8 R9: sweep state against patterns
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 32; s++) begin
        if (p < N) pat = N'(1) << p;
        else if (p == 13) pat = '0;
        else if (p == 14) pat = '1;
        else pat = 13'h1218;
        load(pat);
        deliver(5'(s), "R3");
      end
    end

    // R6 external stays pending across repeated delivery
    load(13'h0008);
    deliver(5'b10000, "R6");
    deliver(5'b10000, "R6");
    // R7 critical external stays pending
    load(13'h0010);
    deliver(5'b01000, "R7");
    deliver(5'b01000, "R7");
    // R8 decrementer clears (default), then nothing left
    load(13'h0200);
    deliver(5'b10000, "R8");
    deliver(5'b10000, "R8");
    // R4 machine check then reset-free drain
    load(13'h0003);
    deliver(5'b00000, "R4");
    deliver(5'b00000, "R4");
    deliver(5'b00000, "R4");
    // R9 nothing eligible leaves pending intact
    load(13'h0020);
    deliver(5'b00000, "R9");
    deliver(5'b10000, "R9");

    // R2 set and clear in the same cycle ends set
    load(13'h0000);
    @(negedge clk); set_i = 13'h0400; clr_i = 13'h0400; tick();
    check(irq_req_o == 1'b1, "R2", irq_req_o, 1);
    @(negedge clk); set_i = '0; clr_i = '0; model = 13'h0400;
    deliver(5'b10000, "R2");
    // R2 clear port alone
    load(13'h0800);
    @(negedge clk); clr_i = 13'h0800; tick();
    check(irq_req_o == 1'b0, "R2", irq_req_o, 0);
    @(negedge clk); clr_i = '0;

    // R10 power save discards hypervisor decrementer only
    load(13'h0004 | 13'h1000);
    @(negedge clk); pwr_save_i = 1'b1; tick();
    @(negedge clk); pwr_save_i = 1'b0; model = 13'h1000;
    deliver(5'b10010, "R10");
    check(irq_req_o == 1'b0, "R10", irq_req_o, 0);

    // R12 no deliver strobe gives no grant, grant lasts one cycle
    load(13'h0001);
    @(negedge clk); deliver_i = 1'b1; tick();
    @(negedge clk); deliver_i = 1'b0; tick();
    check(grant_valid_o == 1'b0 && grant_id_o == 4'd15, "R12", grant_id_o, 15);
    check(irq_req_o == 1'b0, "R12", irq_req_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule